// File: doc/BRIEF.md
# Burst Power Sequencer for a Half-Duplex Transceiver

This block decides when the transmit and receive analog sections of a half-duplex front end are powered. It works from burst enable strobes and is clocked by the transmit sample clock. When the transmit enable drops, the block does two things. It asks the upstream interpolation filter to flush by forcing the sample stream to midscale for 33 cycles. It also waits a programmable number of cycles before asserting transmit power-down, so that the last samples still in the pipeline leave the converter before it is switched off. A new transmit enable powers the path back up at once and cancels any sequence still running.

The receive power-down follows one of two sources. By default it tracks the inverse of the transmit enable, so receive is on whenever transmit is idle. The other source is a dedicated receive enable. Each path has its own fast power-down enable bit. A configuration register, written through a simple strobe, holds the delay, the receive source and the two enable bits. For each path, a ready status output stands in for analog settling: it rises a fixed number of cycles after that path's power-down goes low.

Top module: `burst_pwr_seq`

## Requirements
- R1: After reset, tx_pd_o=1, rx_pd_o=0, flush_o=0, tx_rdy_o=0 and rx_rdy_o=0. The configuration resets to a delay of 31, receive source 0 and both fast power-down enables set.
- R2: While cfg_wr_i is high, cfg_wdata_i is stored at the clock edge and governs behaviour from the next edge on. The fields are: bits [4:0] delay, bit 5 receive source (1 = rx_en_i), bit 6 transmit fast power-down enable, bit 7 receive fast power-down enable.
- R3: At the edge where a high tx_en_i is first sampled after a low one, tx_pd_o goes to 0.
- R4: Let edge k be the edge where a low tx_en_i is first sampled after a high one, and let D be the delay in force at edge k. If transmit fast power-down is enabled, tx_pd_o goes to 1 at edge k+D. With D=0 this is edge k itself.
- R5: If tx_en_i rises again before that count completes, the count is abandoned and tx_pd_o stays 0.
- R6: flush_o is 1 for exactly the 33 cycles from edge k through edge k+32. A transmit rising edge cuts it short at the edge where that rise is detected.
- R7: tx_data_o is a registered copy of tx_data_i. In every cycle where flush_o is 1, it is instead the midscale code 2^(DW-1).
- R8: With receive source 0, a transmit rising edge sets rx_pd_o to 1 (if receive fast power-down is enabled), and a transmit falling edge sets it to 0, at the same edges as R3 and R4's edge k.
- R9: With receive source 1, a rx_en_i rising edge sets rx_pd_o to 0, and a falling edge sets it to 1 (if receive fast power-down is enabled). Transmit edges then have no effect on rx_pd_o.
- R10: While a path's fast power-down enable is 0, that path's power-down output never goes from 0 to 1.
- R11: Each ready output goes to 1 exactly SETTLE edges after its power-down output goes to 0. It goes to 0 at the same edge its power-down output goes to 1, so the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit burst enable |
| rx_en_i | input | 1 | Receive burst enable (used when receive source is 1) |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration word (delay, receive source, fast enables) |
| tx_data_i | input | DW | Transmit samples from the interpolation filter |
| tx_data_o | output | DW | Transmit samples toward the converter |
| flush_o | output | 1 | Flush request to the interpolation filter |
| tx_pd_o | output | 1 | Transmit power-down |
| rx_pd_o | output | 1 | Receive power-down |
| tx_rdy_o | output | 1 | Transmit path settled |
| rx_rdy_o | output | 1 | Receive path settled |

## Verification
A wrong delay counter or a mislatched delay shows up as tx_pd_o rising one or more edges away from edge k+D. The reference model catches this on the first cycle where the two disagree, which is at most 31 cycles after the burst ends. A faulty flush counter makes flush_o and the midscale samples on tx_data_o end early or late, visible at edge k+33 at the latest. A wrong receive source or edge polarity flips rx_pd_o at the very edge where the enable changes. A settling counter that is off by one moves a ready output by a cycle, at SETTLE edges after power-up.

// File: rtl/burst_pwr_pkg.sv
package burst_pwr_pkg;
  localparam int unsigned DLY_W     = 5;
  localparam int unsigned FLUSH_CYC = 33;
  localparam int unsigned FLUSH_W   = $clog2(FLUSH_CYC);

  typedef struct packed {
    logic             rx_fast;
    logic             tx_fast;
    logic             rx_sel;
    logic [DLY_W-1:0] delay;
  } seq_cfg_t;

  localparam int unsigned CFG_W = $bits(seq_cfg_t);

  localparam seq_cfg_t CFG_RST = '{
    rx_fast: 1'b1,
    tx_fast: 1'b1,
    rx_sel:  1'b0,
    delay:   {DLY_W{1'b1}}
  };
endpackage

// File: rtl/bps_cfg_reg.sv
module bps_cfg_reg
  import burst_pwr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output seq_cfg_t         cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= CFG_RST;
    else if (wr_i) cfg_o <= seq_cfg_t'(wdata_i);
  end
endmodule

// File: rtl/bps_tx_seq.sv
module bps_tx_seq
  import burst_pwr_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          fall_i,
  input  seq_cfg_t      cfg_i,
  input  logic [DW-1:0] data_i,
  output logic          pd_d_o,
  output logic          pd_o,
  output logic          flush_o,
  output logic [DW-1:0] data_o
);
  localparam logic [DW-1:0] MID = DW'(1) << (DW-1);

  logic [DLY_W-1:0]   cnt_q, cnt_d;
  logic               act_q, act_d;
  logic [FLUSH_W-1:0] fcnt_q, fcnt_d;
  logic               flush_d;

  always_comb begin
    pd_d_o  = pd_o;
    act_d   = act_q;
    cnt_d   = cnt_q;
    flush_d = flush_o;
    fcnt_d  = fcnt_q;
    if (rise_i) begin
      // burst restart: abort everything, power up now
      pd_d_o  = 1'b0;
      act_d   = 1'b0;
      cnt_d   = '0;
      flush_d = 1'b0;
      fcnt_d  = '0;
    end else if (fall_i) begin
      flush_d = 1'b1;
      fcnt_d  = FLUSH_W'(FLUSH_CYC - 1);
      if (cfg_i.delay == '0) begin
        pd_d_o = pd_o | cfg_i.tx_fast;
      end else begin
        act_d = 1'b1;
        cnt_d = cfg_i.delay - 1'b1;
      end
    end else begin
      if (act_q) begin
        if (cnt_q == '0) begin
          act_d  = 1'b0;
          pd_d_o = pd_o | cfg_i.tx_fast;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      if (flush_o) begin
        if (fcnt_q == '0) flush_d = 1'b0;
        else              fcnt_d  = fcnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_o    <= 1'b1;
      act_q   <= 1'b0;
      cnt_q   <= '0;
      flush_o <= 1'b0;
      fcnt_q  <= '0;
      data_o  <= '0;
    end else begin
      pd_o    <= pd_d_o;
      act_q   <= act_d;
      cnt_q   <= cnt_d;
      flush_o <= flush_d;
      fcnt_q  <= fcnt_d;
      data_o  <= flush_d ? MID : data_i;
    end
  end
endmodule

// File: rtl/bps_rx_ctl.sv
module bps_rx_ctl
  import burst_pwr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tx_rise_i,
  input  logic     tx_fall_i,
  input  logic     rx_rise_i,
  input  logic     rx_fall_i,
  input  seq_cfg_t cfg_i,
  output logic     pd_d_o,
  output logic     pd_o
);
  always_comb begin
    pd_d_o = pd_o;
    if (!cfg_i.rx_sel) begin
      if (tx_rise_i)      pd_d_o = pd_o | cfg_i.rx_fast;
      else if (tx_fall_i) pd_d_o = 1'b0;
    end else begin
      if (rx_rise_i)      pd_d_o = 1'b0;
      else if (rx_fall_i) pd_d_o = pd_o | cfg_i.rx_fast;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pd_o <= 1'b0;
    else         pd_o <= pd_d_o;
  end
endmodule

// File: rtl/bps_settle_timer.sv
module bps_settle_timer #(
  parameter int unsigned SETTLE = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_d_i,
  output logic rdy_o
);
  localparam int unsigned CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LIM = CW'(SETTLE);

  logic [CW-1:0] cnt_q;

  // fed from next-state power-down so ready drops on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_o <= 1'b0;
    end else if (pd_d_i) begin
      cnt_q <= '0;
      rdy_o <= 1'b0;
    end else begin
      rdy_o <= rdy_o | (cnt_q == LIM);
      if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/burst_pwr_seq.sv
module burst_pwr_seq
  import burst_pwr_pkg::*;
#(
  parameter int unsigned DW     = 12,
  parameter int unsigned SETTLE = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_en_i,
  input  logic          rx_en_i,
  input  logic          cfg_wr_i,
  input  logic [7:0]    cfg_wdata_i,
  input  logic [DW-1:0] tx_data_i,
  output logic [DW-1:0] tx_data_o,
  output logic          flush_o,
  output logic          tx_pd_o,
  output logic          rx_pd_o,
  output logic          tx_rdy_o,
  output logic          rx_rdy_o
);
  localparam int unsigned NPATH = 2;

  seq_cfg_t   cfg_q;
  logic       tx_en_q, rx_en_q;
  logic       tx_rise, tx_fall, rx_rise, rx_fall;
  logic [NPATH-1:0] pd_d, rdy;

  bps_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i),
    .wdata_i (cfg_wdata_i[CFG_W-1:0]),
    .cfg_o   (cfg_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
    end else begin
      tx_en_q <= tx_en_i;
      rx_en_q <= rx_en_i;
    end
  end

  assign tx_rise =  tx_en_i & ~tx_en_q;
  assign tx_fall = ~tx_en_i &  tx_en_q;
  assign rx_rise =  rx_en_i & ~rx_en_q;
  assign rx_fall = ~rx_en_i &  rx_en_q;

  bps_tx_seq #(.DW(DW)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (tx_rise),
    .fall_i  (tx_fall),
    .cfg_i   (cfg_q),
    .data_i  (tx_data_i),
    .pd_d_o  (pd_d[0]),
    .pd_o    (tx_pd_o),
    .flush_o (flush_o),
    .data_o  (tx_data_o)
  );

  bps_rx_ctl u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_rise_i (tx_rise),
    .tx_fall_i (tx_fall),
    .rx_rise_i (rx_rise),
    .rx_fall_i (rx_fall),
    .cfg_i     (cfg_q),
    .pd_d_o    (pd_d[1]),
    .pd_o      (rx_pd_o)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_settle
    bps_settle_timer #(.SETTLE(SETTLE)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pd_d_i (pd_d[p]),
      .rdy_o  (rdy[p])
    );
  end

  assign tx_rdy_o = rdy[0];
  assign rx_rdy_o = rdy[1];
endmodule

// File: rtl/bps_checker.sv
module bps_checker
  import burst_pwr_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_en_i,
  input logic [DW-1:0] tx_data_o,
  input logic          flush_o,
  input logic          tx_pd_o,
  input logic          rx_pd_o,
  input logic          tx_rdy_o,
  input logic          rx_rdy_o,
  input seq_cfg_t      cfg_i
);
  localparam logic [DW-1:0] MID = DW'(1) << (DW-1);

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  a_r3_rise_powers_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && tx_en_i && !$past(tx_en_i)) |=> !tx_pd_o);

  a_r6_flush_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !tx_en_i && $past(tx_en_i)) |=> flush_o);

  a_r7_flush_midscale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (tx_data_o == MID));

  a_r8_rx_down_on_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !cfg_i.rx_sel && cfg_i.rx_fast && tx_en_i && !$past(tx_en_i)) |=> rx_pd_o);

  a_r10_tx_no_fast_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.tx_fast && !tx_pd_o) |=> !tx_pd_o);

  a_r11_tx_rdy_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_pd_o && tx_rdy_o));

  a_r11_rx_rdy_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_pd_o && rx_rdy_o));
endmodule

bind burst_pwr_seq bps_checker #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_en_i   (tx_en_i),
  .tx_data_o (tx_data_o),
  .flush_o   (flush_o),
  .tx_pd_o   (tx_pd_o),
  .rx_pd_o   (rx_pd_o),
  .tx_rdy_o  (tx_rdy_o),
  .rx_rdy_o  (rx_rdy_o),
  .cfg_i     (cfg_q)
);

// File: tb/burst_pwr_seq_bench.sv
`timescale 1ns/1ps
module burst_pwr_seq_bench;
  localparam int DW = 12;
  localparam int SETTLE = 8;
  localparam logic [DW-1:0] MID = 12'h800;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tx_en = 1'b0, rx_en = 1'b0, cfg_wr = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          flush, tx_pd, rx_pd, tx_rdy, rx_rdy;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_pwr_seq #(.DW(DW), .SETTLE(SETTLE)) u_burst_pwr_seq (
    .clk_i(clk), .rst_ni(rst_ni), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata), .tx_data_i(din),
    .tx_data_o(dout), .flush_o(flush), .tx_pd_o(tx_pd), .rx_pd_o(rx_pd),
    .tx_rdy_o(tx_rdy), .rx_rdy_o(rx_rdy)
  );

  // behavioural reference model
  int  m_delay, m_rem, m_fleft;
  bit  m_rxsel, m_txf, m_rxf, m_act, m_txq, m_rxq, m_txpd, m_rxpd;
  int  m_cnt[2];
  bit  m_rdy[2];
  logic [DW-1:0] m_data;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_delay = 31; m_rxsel = 0; m_txf = 1; m_rxf = 1;
      m_act = 0; m_rem = 0; m_fleft = 0; m_txq = 0; m_rxq = 0;
      m_txpd = 1; m_rxpd = 0; m_data = '0;
      for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_rdy[i] = 0; end
    end else begin
      bit trise, tfall, rrise, rfall;
      bit pdn[2];
      trise = tx_en && !m_txq; tfall = !tx_en && m_txq;
      rrise = rx_en && !m_rxq; rfall = !rx_en && m_rxq;
      if (trise) begin
        m_txpd = 0; m_act = 0; m_fleft = 0;
      end else if (tfall) begin
        m_fleft = 33;
        if (m_delay == 0) m_txpd = m_txpd | m_txf;
        else begin m_act = 1; m_rem = m_delay; end
      end else begin
        if (m_act) begin
          m_rem--;
          if (m_rem == 0) begin m_act = 0; m_txpd = m_txpd | m_txf; end
        end
        if (m_fleft > 0) m_fleft--;
      end
      m_data = (m_fleft > 0) ? MID : din;
      if (!m_rxsel) begin
        if (trise) m_rxpd = m_rxpd | m_rxf;
        else if (tfall) m_rxpd = 0;
      end else begin
        if (rrise) m_rxpd = 0;
        else if (rfall) m_rxpd = m_rxpd | m_rxf;
      end
      pdn[0] = m_txpd; pdn[1] = m_rxpd;
      for (int i = 0; i < 2; i++) begin
        if (pdn[i]) begin m_cnt[i] = 0; m_rdy[i] = 0; end
        else begin
          if (m_cnt[i] == SETTLE) m_rdy[i] = 1;
          else m_cnt[i]++;
        end
      end
      if (cfg_wr) begin
        m_delay = int'(cfg_wdata[4:0]); m_rxsel = cfg_wdata[5];
        m_txf = cfg_wdata[6]; m_rxf = cfg_wdata[7];
      end
      m_txq = tx_en; m_rxq = rx_en;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: compare everything at the falling edge, then drive
  task automatic cyc();
    @(negedge clk);
    chk("R4 tx_pd_o", 32'(tx_pd), 32'(m_txpd));
    chk("R6 flush_o", 32'(flush), 32'(m_fleft > 0));
    chk("R7 tx_data_o", 32'(dout), 32'(m_data));
    chk("R8 rx_pd_o", 32'(rx_pd), 32'(m_rxpd));
    chk("R11 tx_rdy_o", 32'(tx_rdy), 32'(m_rdy[0]));
    chk("R11 rx_rdy_o", 32'(rx_rdy), 32'(m_rdy[1]));
    cfg_wr = 1'b0;
    din = DW'($urandom);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wcfg(input int dly, input bit sel, input bit txf, input bit rxf);
    cyc();
    cfg_wr = 1'b1;
    cfg_wdata = {rxf, txf, sel, 5'(dly)};
    din = DW'($urandom);
  endtask

  task automatic burst(input int on, input int off);
    cyc(); tx_en = 1'b1; run(on);
    cyc(); tx_en = 1'b0; run(off);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tx_pd_o", 32'(tx_pd), 1);
    chk("R1 rx_pd_o", 32'(rx_pd), 0);
    chk("R1 flush_o", 32'(flush), 0);
    chk("R1 rdy", 32'({tx_rdy, rx_rdy}), 0);
    rst_ni = 1'b1;
    run(12);
    // R1 default delay 31 seen through burst timing
    burst(10, 45);
    // R3 immediate power-up
    cyc(); tx_en = 1'b1;
    cyc(); chk("R3 tx_pd_o", 32'(tx_pd), 0);
    run(12);
    cyc(); tx_en = 1'b0; run(40);
    // R2 delay 0 and 1
    wcfg(0, 0, 1, 1); run(2);
    burst(15, 40);
    wcfg(1, 0, 1, 1); run(2);
    burst(3, 40);
    // R5 abort during count and flush
    wcfg(5, 0, 1, 1); run(2);
    cyc(); tx_en = 1'b1; run(12);
    cyc(); tx_en = 1'b0; run(3);
    cyc(); tx_en = 1'b1; run(8);
    chk("R5 tx_pd_o", 32'(tx_pd), 0);
    chk("R5 flush_o", 32'(flush), 0);
    cyc(); tx_en = 1'b0; run(40);
    // R10 transmit fast power-down disabled
    wcfg(2, 0, 0, 1); run(2);
    burst(12, 40);
    chk("R10 tx_pd_o", 32'(tx_pd), 0);
    // R9 receive source from rx_en
    wcfg(4, 1, 1, 1); run(2);
    cyc(); rx_en = 1'b1; run(12);
    cyc(); tx_en = 1'b1; run(5);
    chk("R9 rx_pd_o ignores tx", 32'(rx_pd), 0);
    cyc(); tx_en = 1'b0; run(40);
    cyc(); rx_en = 1'b0; run(3);
    chk("R9 rx_pd_o", 32'(rx_pd), 1);
    cyc(); rx_en = 1'b1; run(12);
    // R10 receive fast power-down disabled
    wcfg(4, 1, 1, 0); run(2);
    cyc(); rx_en = 1'b0; run(6);
    chk("R10 rx_pd_o", 32'(rx_pd), 0);
    // back to default source with receive fast off: R8 and R10
    wcfg(31, 0, 1, 0); run(2);
    burst(10, 40);
    chk("R10 rx_pd_o tx source", 32'(rx_pd), 0);
    wcfg(3, 0, 1, 1); run(2);
    burst(20, 45);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule